// File: doc/BRIEF.md
# Quad SPI memory operation sequencer

This block runs one serial-flash memory operation on up to four bidirectional IO lines. An operation is built from a per-operation configuration word rather than from fixed flash commands. It has an opcode phase that always uses one line, a combined address-and-dummy phase, and an optional data phase that either sends or receives. The lane mode is single, dual or quad. The address-and-dummy phase can be forced onto one line while data uses the wide mode. For reads, the IO output enables are turned off before the first data bit is sampled.

Every byte the block sends comes from an input byte stream with a valid/ready handshake, taken in order. That covers opcode bytes, address bytes, dummy bytes (normally 0xFF) and write data. Read data leaves as a byte stream with a one-cycle valid strobe. The data length is given as a packet size and a packet count, so long transfers stay whole multiples of a packet.

The serial clock runs at half the system clock. It idles low, and data changes only while it is low. When the byte stream has nothing to offer, the serial clock stops low. At the end of an operation a one-cycle done pulse is raised while chip select is still low, and chip select is released on the following cycle.

Top module: `qspi_seq`

## Requirements
- R1: After reset and between operations, cs_no is 1, sclk_o is 0, io_oe_o is 0, done_o is 0 and tx_ready_o is 0.
- R2: The opcode phase takes cfg_i[9:6] bytes from the stream. Each byte goes out on io_o[0] only, with io_oe_o = 4'b0001, MSB first, one bit per serial clock. io_o changes only while sclk_o is low.
- R3: The lane code cfg_i[1:0] selects the data width: 0 is one line, 1 is two lines, 2 or 3 is four lines. In wide mode each serial clock carries 2 or 4 bits of the byte, MSB group first, with the higher bit on the higher-numbered line. Only the lines in use are enabled.
- R4: The address-and-dummy phase takes cfg_i[13:10] bytes (0 to 15) from the stream at the data width. It is skipped entirely when that count is 0.
- R5: When cfg_i[4] is 1, the address-and-dummy bytes go out on io_o[0] only, while the data phase uses the width from R3.
- R6: When cfg_i[5] is 1, the operation ends after the address-and-dummy phase. No further stream bytes are taken and no further serial clocks are produced.
- R7: The data phase receives only when both cfg_i[3] and cfg_i[2] are 1. Otherwise it transmits bytes from the stream. A receive phase takes no stream bytes.
- R8: The data phase moves exactly (pkt_len_i+1)*(pkt_cnt_i+1) bytes, at 8/width serial clocks per byte, with no extra clocks.
- R9: In a receive phase, io_oe_o is 0 from the falling edge of the last address clock until the end of the operation. io_i is sampled at the end of each sclk_o high half, from io_i[1] in single mode and from io_i[1:0] or io_i[3:0] in wide mode. Each byte is presented MSB first on rx_data_o with rx_valid_o high for one cycle.
- R10: done_o is high for exactly one cycle after the final phase completes, with cs_no still 0. cs_no is 1 on the next cycle.
- R11: While tx_ready_o is high and tx_valid_i is low, sclk_o stays low and the operation does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when idle |
| cfg_i | input | 14 | Operation configuration word (field positions are given in R2 to R7) |
| pkt_len_i | input | LEN_W | Bytes per packet minus one |
| pkt_cnt_i | input | CNT_W | Number of packets minus one |
| tx_data_i | input | 8 | Transmit byte stream data |
| tx_valid_i | input | 1 | Transmit byte stream valid |
| tx_ready_o | output | 1 | Transmit byte stream ready |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| io_i | input | 4 | IO line inputs |
| io_o | output | 4 | IO line outputs |
| io_oe_o | output | 4 | IO line output enables |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| done_o | output | 1 | Operation complete pulse |

## Verification
The bench targets the width switch between phases. A single-line opcode is followed by a quad or dual address phase, or by a single-line address with a wide data phase. A design that latched one width per operation would show the wrong output enables or bit grouping on the very next clock.

Receive operations are run in every lane mode. In single mode the unused lines carry inverted or constant noise, so sampling the wrong line or letting the enables stay high into the read is caught. Multi-packet lengths and a zero-length address phase catch off-by-one packet counting and phantom bytes as extra or missing clocks.

Further runs combine the no-data flag, a receive direction without half-duplex enable, and surplus stream bytes with stream gaps. They expose sequencers that keep consuming input after the final phase, or that keep clocking while starved.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;
  localparam int unsigned NUM_IO  = 4;
  localparam int unsigned LEN_F_W = 4;

  typedef struct packed {
    logic [LEN_F_W-1:0] ad_len;
    logic [LEN_F_W-1:0] op_len;
    logic               no_data;
    logic               single_ad;
    logic               hd_en;
    logic               rx_dir;
    logic [1:0]         lane_code;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {W1, W2, W4} width_t;
  typedef enum logic [2:0] {PH_IDLE, PH_OPC, PH_ADR, PH_DAT, PH_FIN} phase_t;

  function automatic width_t code_to_width(logic [1:0] c);
    case (c)
      2'd0:    return W1;
      2'd1:    return W2;
      default: return W4;
    endcase
  endfunction

  // serial clocks per byte, minus one
  function automatic logic [2:0] last_step(width_t w);
    case (w)
      W1:      return 3'd7;
      W2:      return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [NUM_IO-1:0] lane_mask(width_t w);
    case (w)
      W1:      return 4'b0001;
      W2:      return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic phase_t next_phase(phase_t p, cfg_t c);
    phase_t n;
    n = PH_FIN;
    if (p == PH_IDLE && c.op_len != '0) n = PH_OPC;
    else if ((p == PH_IDLE || p == PH_OPC) && c.ad_len != '0) n = PH_ADR;
    else if (p != PH_DAT && !c.no_data) n = PH_DAT;
    return n;
  endfunction
endpackage

// File: rtl/qspi_seq_ctrl.sv
module qspi_seq_ctrl
  import qspi_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  cfg_t             cfg_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [CNT_W-1:0] pkt_cnt_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             byte_end_o,
  output logic             drive_o,
  output width_t           width_o,
  output phase_t           phase_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             done_o
);
  cfg_t             cfg_q;
  phase_t           phase_q, next_ph;
  logic             sclk_q, need_load_q;
  logic [2:0]       step_q;
  logic [LEN_F_W-1:0] byte_left_q;
  logic [LEN_W-1:0] pkt_byte_q, pkt_len_q, enter_len;
  logic [CNT_W-1:0] pkt_left_q, pkt_cnt_q, enter_cnt;
  cfg_t             enter_cfg;
  width_t           cur_w;
  logic             rx_mode, is_rx, tx_phase, running, fall, advance;

  assign rx_mode = cfg_q.hd_en & cfg_q.rx_dir;

  always_comb begin
    case (phase_q)
      PH_OPC:  cur_w = W1;
      PH_ADR:  cur_w = cfg_q.single_ad ? W1 : code_to_width(cfg_q.lane_code);
      default: cur_w = code_to_width(cfg_q.lane_code);
    endcase
  end

  assign is_rx      = (phase_q == PH_DAT) && rx_mode;
  assign tx_phase   = (phase_q == PH_OPC) || (phase_q == PH_ADR) ||
                      ((phase_q == PH_DAT) && !rx_mode);
  assign tx_ready_o = tx_phase && need_load_q;
  assign load_o     = tx_ready_o && tx_valid_i;
  assign running    = (tx_phase && !need_load_q) || is_rx;
  assign fall       = running && sclk_q;
  assign byte_end_o = fall && (step_q == 3'd0);
  assign shift_o    = fall && (step_q != 3'd0);
  assign sample_o   = fall && is_rx;

  assign enter_cfg = (phase_q == PH_IDLE) ? cfg_i : cfg_q;
  assign enter_len = (phase_q == PH_IDLE) ? pkt_len_i : pkt_len_q;
  assign enter_cnt = (phase_q == PH_IDLE) ? pkt_cnt_i : pkt_cnt_q;
  assign next_ph   = next_phase(phase_q, enter_cfg);

  always_comb begin
    advance = 1'b0;
    if (phase_q == PH_IDLE) advance = start_i;
    else if (byte_end_o) begin
      case (phase_q)
        PH_OPC, PH_ADR: advance = (byte_left_q == '0);
        PH_DAT:         advance = (pkt_byte_q == '0) && (pkt_left_q == '0);
        default:        advance = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      phase_q     <= PH_IDLE;
      sclk_q      <= 1'b0;
      need_load_q <= 1'b0;
      step_q      <= '0;
      byte_left_q <= '0;
      pkt_byte_q  <= '0;
      pkt_len_q   <= '0;
      pkt_left_q  <= '0;
      pkt_cnt_q   <= '0;
    end else begin
      if (phase_q == PH_IDLE && start_i) begin
        cfg_q     <= cfg_i;
        pkt_len_q <= pkt_len_i;
        pkt_cnt_q <= pkt_cnt_i;
      end
      if (phase_q == PH_FIN) phase_q <= PH_IDLE;
      if (load_o) begin
        need_load_q <= 1'b0;
        step_q      <= last_step(cur_w);
      end
      if (running) sclk_q <= ~sclk_q;
      if (shift_o) step_q <= step_q - 3'd1;
      if (byte_end_o && !advance) begin
        if (phase_q == PH_DAT) begin
          if (pkt_byte_q == '0) begin
            pkt_left_q <= pkt_left_q - CNT_W'(1);
            pkt_byte_q <= pkt_len_q;
          end else begin
            pkt_byte_q <= pkt_byte_q - LEN_W'(1);
          end
          if (rx_mode) step_q <= last_step(cur_w);
          else         need_load_q <= 1'b1;
        end else begin
          byte_left_q <= byte_left_q - LEN_F_W'(1);
          need_load_q <= 1'b1;
        end
      end
      if (advance) begin
        phase_q <= next_ph;
        case (next_ph)
          PH_OPC: begin
            byte_left_q <= enter_cfg.op_len - LEN_F_W'(1);
            need_load_q <= 1'b1;
          end
          PH_ADR: begin
            byte_left_q <= enter_cfg.ad_len - LEN_F_W'(1);
            need_load_q <= 1'b1;
          end
          PH_DAT: begin
            pkt_byte_q  <= enter_len;
            pkt_left_q  <= enter_cnt;
            need_load_q <= !(enter_cfg.hd_en & enter_cfg.rx_dir);
            step_q      <= last_step(code_to_width(enter_cfg.lane_code));
          end
          default: need_load_q <= 1'b0;
        endcase
      end
    end
  end

  assign drive_o = tx_phase;
  assign width_o = cur_w;
  assign phase_o = phase_q;
  assign sclk_o  = sclk_q;
  assign cs_no   = (phase_q == PH_IDLE);
  assign done_o  = (phase_q == PH_FIN);

  assert_done_then_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cs_no && !done_o));
  assert_stall_clock_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> (!sclk_o && $stable(phase_o)));
  assert_idle_clock_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
endmodule

// File: rtl/qspi_seq_lane.sv
module qspi_seq_lane
  import qspi_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        tx_data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              byte_end_i,
  input  logic              drive_i,
  input  width_t            width_i,
  input  logic [NUM_IO-1:0] io_i,
  output logic [NUM_IO-1:0] io_o,
  output logic [NUM_IO-1:0] io_oe_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_valid_o
);
  logic [7:0]        sh_q, rx_sh_q, rx_nx;
  logic [NUM_IO-1:0] mask;

  assign mask = lane_mask(width_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (load_i) sh_q <= tx_data_i;
    else if (shift_i) begin
      case (width_i)
        W1:      sh_q <= {sh_q[6:0], 1'b0};
        W2:      sh_q <= {sh_q[5:0], 2'b0};
        default: sh_q <= {sh_q[3:0], 4'b0};
      endcase
    end
  end

  for (genvar g = 0; g < NUM_IO; g++) begin : g_lane
    localparam int I1 = 7;
    localparam int I2 = (g < 2) ? 6 + g : 7;
    localparam int I4 = 4 + g;
    logic bit_sel;
    always_comb begin
      case (width_i)
        W1:      bit_sel = sh_q[I1];
        W2:      bit_sel = sh_q[I2];
        default: bit_sel = sh_q[I4];
      endcase
    end
    assign io_oe_o[g] = drive_i & mask[g];
    assign io_o[g]    = drive_i & mask[g] & bit_sel;
  end

  always_comb begin
    case (width_i)
      W1:      rx_nx = {rx_sh_q[6:0], io_i[1]};
      W2:      rx_nx = {rx_sh_q[5:0], io_i[1:0]};
      default: rx_nx = {rx_sh_q[3:0], io_i[3:0]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q    <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= sample_i && byte_end_i;
      if (sample_i) rx_sh_q <= rx_nx;
      if (sample_i && byte_end_i) rx_data_o <= rx_nx;
    end
  end

  assert_oe_shape_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o == 4'h0) || (io_oe_o == 4'h1) || (io_oe_o == 4'h3) || (io_oe_o == 4'hf));
  assert_rx_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> (io_oe_o == '0));
  assert_rx_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [13:0]      cfg_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [CNT_W-1:0] pkt_cnt_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic [3:0]       io_i,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             done_o
);
  logic   load, shift, sample, byte_end, drive;
  width_t width;
  phase_t phase;
  cfg_t   cfg;

  assign cfg = cfg_t'(cfg_i);

  qspi_seq_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cfg_i      (cfg),
    .pkt_len_i  (pkt_len_i),
    .pkt_cnt_i  (pkt_cnt_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .load_o     (load),
    .shift_o    (shift),
    .sample_o   (sample),
    .byte_end_o (byte_end),
    .drive_o    (drive),
    .width_o    (width),
    .phase_o    (phase),
    .sclk_o     (sclk_o),
    .cs_no      (cs_no),
    .done_o     (done_o)
  );

  qspi_seq_lane i_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .tx_data_i  (tx_data_i),
    .shift_i    (shift),
    .sample_i   (sample),
    .byte_end_i (byte_end),
    .drive_i    (drive),
    .width_i    (width),
    .io_i       (io_i),
    .io_o       (io_o),
    .io_oe_o    (io_oe_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  assert_opc_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_OPC) |-> (io_oe_o == 4'b0001));
  assert_io_needs_cs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o != '0) |-> !cs_no);
endmodule

// File: tb/test_qspi_seq.sv
module test_qspi_seq;
  import qspi_seq_pkg::*;
  localparam int LEN_W = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             start = 1'b0;
  logic [13:0]      cfg = '0;
  logic [LEN_W-1:0] plen = '0;
  logic [CNT_W-1:0] pcnt = '0;
  logic [7:0]       tx_data = '0;
  logic             tx_valid = 1'b0;
  logic             tx_ready, rx_valid, sclk, cs_n, done;
  logic [7:0]       rx_data;
  logic [3:0]       io_in = '0;
  logic [3:0]       io_out, io_oe;

  qspi_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_qspi_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_i(cfg),
    .pkt_len_i(plen), .pkt_cnt_i(pcnt), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe),
    .sclk_o(sclk), .cs_no(cs_n), .done_o(done)
  );

  typedef struct {
    logic [3:0] oe;
    logic [3:0] val;
    string      tag;
  } step_t;

  int checks = 0;
  int fails = 0;
  step_t      exp_q[$];
  logic [7:0] tx_q[$];
  logic [7:0] rx_exp_q[$];
  logic [7:0] rx_src[$];
  int  rx_wn = 1;
  int  rx_step = 0;
  bit  gap_mode = 0;
  int  gap_cnt = 0;
  bit  hs_flag = 0;
  bit  prev_sclk = 0;
  logic [3:0] prev_oe = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // stream source, scoreboard monitor and read-side device model
  always @(negedge clk) begin : mon
    step_t e;
    int bp, bi, off;
    logic [3:0] grp;
    if (hs_flag) begin
      void'(tx_q.pop_front());
      if (gap_mode) gap_cnt = 3;
    end
    if (gap_cnt > 0) begin
      tx_valid = 1'b0;
      gap_cnt--;
    end else begin
      tx_valid = (tx_q.size() > 0);
      tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    end
    hs_flag = tx_ready && tx_valid;
    if (rst_n && tx_ready && !tx_valid) chk(!sclk, "R11", "sclk while starved", sclk, 0);
    if (sclk && !prev_sclk) begin
      if (exp_q.size() == 0) chk(0, "R8", "extra clock", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk(io_oe == e.oe, e.tag, "oe", io_oe, e.oe);
        chk((io_out & io_oe) == e.val, e.tag, "io", io_out & io_oe, e.val);
      end
    end
    if (prev_sclk && !sclk && prev_oe == 0 && io_oe == 0 && !cs_n) rx_step++;
    bp = rx_step * rx_wn;
    bi = bp / 8;
    off = bp % 8;
    if (bi < rx_src.size()) begin
      grp = 4'((rx_src[bi] >> (8 - rx_wn - off)) & ((1 << rx_wn) - 1));
      case (rx_wn)
        1:       io_in = {2'b10, grp[0], ~grp[0]};
        2:       io_in = {2'b01, grp[1:0]};
        default: io_in = grp;
      endcase
    end
    if (rx_valid) begin
      if (rx_exp_q.size() == 0) chk(0, "R9", "extra rx byte", rx_data, 0);
      else begin
        logic [7:0] x;
        x = rx_exp_q.pop_front();
        chk(rx_data == x, "R9", "rx byte", rx_data, x);
      end
    end
    prev_sclk = sclk;
    prev_oe = io_oe;
  end

  task automatic push_byte(input logic [7:0] b, input int wn, input bit rx,
                           input string tag);
    for (int s = 0; s < 8 / wn; s++) begin
      step_t e;
      e.oe  = rx ? 4'h0 : 4'((1 << wn) - 1);
      e.val = rx ? 4'h0 : 4'((b >> (8 - wn * (s + 1))) & ((1 << wn) - 1));
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic run_op(input cfg_t c, input int pl, input int pc,
                        input logic [7:0] op[$], input logic [7:0] ad[$],
                        input logic [7:0] dat[$], input int extra,
                        input string tag);
    int wn, adw, n;
    bit rx;
    wn  = (c.lane_code == 0) ? 1 : (c.lane_code == 1) ? 2 : 4;
    adw = c.single_ad ? 1 : wn;
    rx  = c.hd_en && c.rx_dir;
    @(negedge clk);
    foreach (op[i]) begin tx_q.push_back(op[i]); push_byte(op[i], 1, 0, "R2"); end
    foreach (ad[i]) begin
      tx_q.push_back(ad[i]);
      push_byte(ad[i], adw, 0, c.single_ad ? "R5" : "R4");
    end
    rx_src.delete();
    rx_step = 0;
    rx_wn = wn;
    if (!c.no_data) begin
      foreach (dat[i]) begin
        if (rx) begin
          rx_src.push_back(dat[i]);
          rx_exp_q.push_back(dat[i]);
          push_byte(dat[i], wn, 1, "R9");
        end else begin
          tx_q.push_back(dat[i]);
          push_byte(dat[i], wn, 0, tag);
        end
      end
    end
    for (int i = 0; i < extra; i++) tx_q.push_back(8'hA5);
    cfg  = c;
    plen = LEN_W'(pl);
    pcnt = CNT_W'(pc);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R10", "done seen", done, 1);
    chk(cs_n == 1'b0, "R10", "cs low at done", cs_n, 0);
    @(negedge clk);
    chk(cs_n == 1'b1 && done == 1'b0, "R10", "release after done", {cs_n, done}, 2);
    chk(exp_q.size() == 0, "R8", "clocks missing", exp_q.size(), 0);
    chk(rx_exp_q.size() == 0, "R9", "rx bytes missing", rx_exp_q.size(), 0);
    chk(tx_q.size() == extra, (c.no_data || rx) ? "R6" : tag, "stream left",
        tx_q.size(), extra);
    exp_q.delete();
    rx_exp_q.delete();
    tx_q.delete();
    repeat (3) @(negedge clk);
  endtask

  function automatic cfg_t mk(input int ln, input bit rxd, input bit hd,
                              input bit sa, input bit nd, input int ol,
                              input int al);
    cfg_t c;
    c.lane_code = 2'(ln);
    c.rx_dir    = rxd;
    c.hd_en     = hd;
    c.single_ad = sa;
    c.no_data   = nd;
    c.op_len    = 4'(ol);
    c.ad_len    = 4'(al);
    return c;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] none[$];
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs in reset", cs_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs idle", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk idle", sclk, 0);
    chk(io_oe == 4'h0, "R1", "oe idle", io_oe, 0);
    chk(done == 1'b0, "R1", "done idle", done, 0);
    chk(tx_ready == 1'b0, "R1", "ready idle", tx_ready, 0);

    // single-line write, 3 address bytes, 4 data bytes
    run_op(mk(0, 0, 1, 0, 0, 1, 3), 3, 0, '{8'h02}, '{8'h12, 8'h34, 8'h56},
           '{8'hC3, 8'h5A, 8'h81, 8'h7E}, 0, "R7");
    // quad read, address forced to one line, 3 packets of 2 bytes
    run_op(mk(2, 1, 1, 1, 0, 1, 4), 1, 2, '{8'h6B}, '{8'hA1, 8'hB2, 8'hC3, 8'hFF},
           '{8'h1E, 8'hE1, 8'h96, 8'h69, 8'h3C, 8'hC3}, 2, "R5");
    // dual read with dual address, 5 bytes
    run_op(mk(1, 1, 1, 0, 0, 1, 2), 4, 0, '{8'hBB}, '{8'h9C, 8'hFF},
           '{8'hB4, 8'h4B, 8'h0F, 8'hF0, 8'h55}, 0, "R3");
    // single-line read sampled from io1
    run_op(mk(0, 1, 1, 0, 0, 1, 1), 1, 0, '{8'h03}, '{8'h40},
           '{8'hA7, 8'h39}, 1, "R9");
    // no data phase, spare stream bytes stay untouched
    run_op(mk(2, 0, 1, 0, 1, 1, 3), 0, 0, '{8'h20}, '{8'h01, 8'h80, 8'h7F},
           '{8'h11}, 3, "R6");
    // quad write, no address phase, starved stream
    gap_mode = 1;
    run_op(mk(2, 0, 1, 0, 0, 1, 0), 2, 0, '{8'h38}, none,
           '{8'hD2, 8'h2D, 8'h8E}, 0, "R4");
    gap_mode = 0;
    // receive direction without half-duplex enable still transmits
    run_op(mk(1, 1, 0, 0, 0, 1, 1), 1, 0, '{8'hA2}, '{8'h66},
           '{8'hE7, 8'h18}, 0, "R7");
    // two opcode bytes, lane code 3 as quad, 4 packets of 1 byte
    run_op(mk(3, 0, 1, 0, 0, 2, 1), 0, 3, '{8'hF0, 8'h0D}, '{8'h5C},
           '{8'h12, 8'h34, 8'h56, 8'h78}, 0, "R8");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule